// File: doc/BRIEF.md
# Multi-Mode Pixel Calibration Timing Sequencer

This block drives the row control strobes of an image sensor during a linearity calibration sweep. Once started, it runs a fixed number of samples (steps). For every step it performs one correlated double sampling readout. First the pixel reset line is held high while the column amplifier auto-zeroes and then the ADC auto-zeroes. Next comes a transfer phase, then a sample-and-hold strobe, and finally a one-cycle conversion start. After the conversion start the step index advances.

The stimulus that grows from step to step depends on the mode selected at start:
- **Pixel mode** lengthens the exposure by one base unit per step. The exposure is framed by the falling edges of the transfer strobe.
- **Voltage mode** keeps the transfer strobe low. It drives a reset-drain level output that takes two values within each step: a fixed reset level, and a signal level that drops by a programmable decrement every step.
- **Current mode** keeps the transfer strobe low. It widens a calibration-current enable pulse by one base unit per step, and it drives a complementary dummy-switch strobe.

Control and status pins are plain levels and pulses. No data stream crosses the block boundary, so there is no valid/ready handshake and no back-pressure. The base unit and the strobe pulse length are given in clock cycles. For example, a 60 ns unit at 100 MHz is 6 cycles.

Top module: `pcal_seq`

## Requirements
- R1: While reset is asserted and afterwards until a start is accepted, the outputs are as follows. All strobes (rst_pix_o, az_amp_o, az_adc_o, tx_o, sh_o, adc_start_o, ical_en_o) are low. ical_en_b_o is high. vdrain_o is 0, step_idx_o is 0, busy_o and done_o are 0, and mode_o is 2'b00.
- R2: A start pulse is accepted only when busy_o is low and mode_i is one of 2'b00 (pixel), 2'b01 (voltage) or 2'b10 (current). A start with mode_i = 2'b11, or any start while busy_o is high, changes nothing. mode_o shows the mode latched at the last accepted start and holds it through the sweep.
- R3: The readout of every step follows this order, with P = pulse_cyc_i (0 treated as 1):
  - P cycles with rst_pix_o and az_amp_o high;
  - P cycles with rst_pix_o and az_adc_o high;
  - the mode's transfer phase;
  - P cycles with sh_o high;
  - one cycle with adc_start_o high.
- R4: In pixel mode, each step begins with P cycles in which rst_pix_o and tx_o are both high. Then follow (k+1)·U cycles with no strobe, where k is the step index and U = unit_cyc_i (0 treated as 1). The transfer phase is P cycles with only tx_o high. The two falling edges of tx_o within step k are therefore (k+1)·U + 3·P cycles apart.
- R5: In voltage mode, tx_o stays low for the whole sweep. The transfer phase is P cycles with only rst_pix_o high. During the sweep, vdrain_o equals the latched reset level H, except during the transfer and sample-and-hold phases, where it equals max(H − (k+1)·D, 0) with D the latched decrement. Outside a voltage-mode sweep vdrain_o is 0.
- R6: In current mode, tx_o stays low for the whole sweep. The transfer phase is a single contiguous pulse of ical_en_o lasting (k+1)·U cycles, placed between the ADC auto-zero phase and the sample-and-hold phase. ical_en_o is never high in another mode.
- R7: ical_en_b_o is the inverse of ical_en_o in every cycle.
- R8: step_idx_o holds k for the whole of step k and rises by one in the cycle after adc_start_o. After the conversion of step NUM_STEPS−1, the sweep ends as follows:
  - busy_o falls;
  - step_idx_o holds NUM_STEPS−1;
  - done_o stays high until the next accepted start, which clears it.
- R9: The following inputs are captured when a start is accepted: unit_cyc_i, pulse_cyc_i, vd_hi_i and vd_dec_i. A zero unit or pulse length is treated as 1. Changes to these inputs, to mode_i or to start_i during a sweep have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a sweep |
| mode_i | input | 2 | Sweep mode: 00 pixel, 01 voltage, 10 current |
| unit_cyc_i | input | UNIT_W | Base stimulus unit in cycles |
| pulse_cyc_i | input | PULSE_W | Length of each fixed strobe phase in cycles |
| vd_hi_i | input | DAC_W | Voltage-mode reset level |
| vd_dec_i | input | DAC_W | Voltage-mode per-step decrement |
| rst_pix_o | output | 1 | Pixel reset strobe |
| az_amp_o | output | 1 | Column amplifier auto-zero |
| az_adc_o | output | 1 | ADC auto-zero |
| tx_o | output | 1 | Charge transfer strobe |
| sh_o | output | 1 | Sample-and-hold strobe |
| adc_start_o | output | 1 | Conversion start pulse |
| ical_en_o | output | 1 | Calibration-current enable |
| ical_en_b_o | output | 1 | Complementary dummy-switch strobe |
| vdrain_o | output | DAC_W | Reset-drain level code |
| step_idx_o | output | SW | Current step index |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep finished |
| mode_o | output | 2 | Mode of the current or last sweep |

## Verification
The assertions place no constraint on the data inputs. Their properties rest on the sequencer's own phase order and on the mode it latched, never on the live values of mode_i or the timing settings. The only input ordering they rely on is that the reset is released synchronously with respect to the checks. To show that nothing outside the start handshake matters, the random runs flip start_i, mode_i, the cycle counts and the voltage settings in every cycle of a sweep. Directed runs reach the corner cases: zero-length settings, an illegal mode code, and a decrement that saturates the signal level at zero.

// File: rtl/pcal_pkg.sv
package pcal_pkg;

  typedef enum logic [1:0] {
    MD_PIX  = 2'b00,
    MD_VOLT = 2'b01,
    MD_CUR  = 2'b10,
    MD_NONE = 2'b11
  } mode_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_PDRST,
    PH_EXPO,
    PH_AZAMP,
    PH_AZADC,
    PH_XFER,
    PH_ICAL,
    PH_SH,
    PH_CONV
  } phase_e;

  function automatic logic ph_is_timed(phase_e p);
    return (p == PH_EXPO) || (p == PH_ICAL);
  endfunction

endpackage

// File: rtl/pcal_unit_timer.sv
// Counts (target+1) units of UNIT cycles without a multiplier.
module pcal_unit_timer #(
  parameter int UNIT_W = 8,
  parameter int SW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [UNIT_W-1:0] unit,
  input  logic [SW-1:0]     target,
  output logic              last
);
  logic [UNIT_W-1:0] ucnt_q;
  logic [SW-1:0]     kcnt_q;
  logic              unit_end;

  assign unit_end = (ucnt_q == unit - 1'b1);
  assign last     = run && unit_end && (kcnt_q == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ucnt_q <= '0;
      kcnt_q <= '0;
    end else if (!run) begin
      ucnt_q <= '0;
      kcnt_q <= '0;
    end else if (unit_end) begin
      ucnt_q <= '0;
      kcnt_q <= kcnt_q + 1'b1;
    end else begin
      ucnt_q <= ucnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcal_drain_ramp.sv
// Voltage-mode signal level: starts one decrement below the reset level and
// drops by one more decrement per step, saturating at zero.
module pcal_drain_ramp #(
  parameter int DAC_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [DAC_W-1:0] hi_in,
  input  logic [DAC_W-1:0] dec_in,
  output logic [DAC_W-1:0] sig
);
  logic [DAC_W-1:0] dec_q;
  logic [DAC_W-1:0] sig_q;

  function automatic logic [DAC_W-1:0] sat_sub(logic [DAC_W-1:0] a,
                                               logic [DAC_W-1:0] b);
    return (a < b) ? '0 : (a - b);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= '0;
      sig_q <= '0;
    end else if (load) begin
      dec_q <= dec_in;
      sig_q <= sat_sub(hi_in, dec_in);
    end else if (adv) begin
      sig_q <= sat_sub(sig_q, dec_q);
    end
  end

  assign sig = sig_q;
endmodule

// File: rtl/pcal_strobe_dec.sv
// Maps the phase and latched mode onto the row strobes and drain level.
module pcal_strobe_dec
  import pcal_pkg::*;
#(
  parameter int DAC_W = 14
) (
  input  phase_e           ph,
  input  mode_e            mode,
  input  logic [DAC_W-1:0] hi,
  input  logic [DAC_W-1:0] sig,
  output logic             rst_pix,
  output logic             az_amp,
  output logic             az_adc,
  output logic             tx,
  output logic             sh,
  output logic             adc_start,
  output logic             ical_en,
  output logic             ical_en_b,
  output logic [DAC_W-1:0] vdrain
);
  logic in_ical;

  always_comb begin
    in_ical   = (ph == PH_ICAL);
    rst_pix   = (ph == PH_PDRST) || (ph == PH_AZAMP) || (ph == PH_AZADC) ||
                ((ph == PH_XFER) && (mode == MD_VOLT));
    az_amp    = (ph == PH_AZAMP);
    az_adc    = (ph == PH_AZADC);
    tx        = (ph == PH_PDRST) || ((ph == PH_XFER) && (mode == MD_PIX));
    sh        = (ph == PH_SH);
    adc_start = (ph == PH_CONV);
    ical_en   = in_ical;
    ical_en_b = !in_ical;
    if ((mode != MD_VOLT) || (ph == PH_IDLE))
      vdrain = '0;
    else if ((ph == PH_XFER) || (ph == PH_SH))
      vdrain = sig;
    else
      vdrain = hi;
  end
endmodule

// File: rtl/pcal_seq.sv
module pcal_seq
  import pcal_pkg::*;
#(
  parameter int NUM_STEPS = 4096,
  parameter int UNIT_W    = 8,
  parameter int PULSE_W   = 8,
  parameter int DAC_W     = 14,
  localparam int SW       = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic [UNIT_W-1:0]  unit_cyc_i,
  input  logic [PULSE_W-1:0] pulse_cyc_i,
  input  logic [DAC_W-1:0]   vd_hi_i,
  input  logic [DAC_W-1:0]   vd_dec_i,
  output logic               rst_pix_o,
  output logic               az_amp_o,
  output logic               az_adc_o,
  output logic               tx_o,
  output logic               sh_o,
  output logic               adc_start_o,
  output logic               ical_en_o,
  output logic               ical_en_b_o,
  output logic [DAC_W-1:0]   vdrain_o,
  output logic [SW-1:0]      step_idx_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [1:0]         mode_o
);
  localparam logic [SW-1:0] LAST_STEP = SW'(NUM_STEPS - 1);

  phase_e             ph_q, ph_nx;
  mode_e              mode_q, mode_in;
  logic [UNIT_W-1:0]  unit_q;
  logic [PULSE_W-1:0] pls_q;
  logic [PULSE_W-1:0] pcnt_q;
  logic [DAC_W-1:0]   hi_q;
  logic [DAC_W-1:0]   sig_w;
  logic [SW-1:0]      step_q;
  logic               done_q;
  logic               accept, fixed_last, tmr_last, last_step, adv;

  assign mode_in    = mode_e'(mode_i);
  assign accept     = start_i && (ph_q == PH_IDLE) && (mode_in != MD_NONE);
  assign fixed_last = (pcnt_q == pls_q - 1'b1);
  assign last_step  = (step_q == LAST_STEP);
  assign adv        = (ph_q == PH_CONV) && !last_step;

  // Phase sequencing
  always_comb begin
    ph_nx = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (accept) ph_nx = (mode_in == MD_PIX) ? PH_PDRST : PH_AZAMP;
      PH_PDRST: if (fixed_last) ph_nx = PH_EXPO;
      PH_EXPO:  if (tmr_last) ph_nx = PH_AZAMP;
      PH_AZAMP: if (fixed_last) ph_nx = PH_AZADC;
      PH_AZADC: if (fixed_last) ph_nx = (mode_q == MD_CUR) ? PH_ICAL : PH_XFER;
      PH_XFER:  if (fixed_last) ph_nx = PH_SH;
      PH_ICAL:  if (tmr_last) ph_nx = PH_SH;
      PH_SH:    if (fixed_last) ph_nx = PH_CONV;
      PH_CONV:  ph_nx = last_step ? PH_IDLE
                      : ((mode_q == MD_PIX) ? PH_PDRST : PH_AZAMP);
      default:  ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      pcnt_q <= '0;
    end else begin
      ph_q   <= ph_nx;
      pcnt_q <= ((ph_nx != ph_q) || (ph_q == PH_IDLE)) ? '0 : pcnt_q + 1'b1;
    end
  end

  // Settings captured at start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_PIX;
      unit_q <= UNIT_W'(1);
      pls_q  <= PULSE_W'(1);
      hi_q   <= '0;
    end else if (accept) begin
      mode_q <= mode_in;
      unit_q <= (unit_cyc_i == '0) ? UNIT_W'(1) : unit_cyc_i;
      pls_q  <= (pulse_cyc_i == '0) ? PULSE_W'(1) : pulse_cyc_i;
      hi_q   <= vd_hi_i;
    end
  end

  // Step index and completion flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      done_q <= 1'b0;
    end else if (accept) begin
      step_q <= '0;
      done_q <= 1'b0;
    end else if (ph_q == PH_CONV) begin
      if (last_step) done_q <= 1'b1;
      else           step_q <= step_q + 1'b1;
    end
  end

  pcal_unit_timer #(.UNIT_W(UNIT_W), .SW(SW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ph_is_timed(ph_q)),
    .unit   (unit_q),
    .target (step_q),
    .last   (tmr_last)
  );

  pcal_drain_ramp #(.DAC_W(DAC_W)) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .adv    (adv),
    .hi_in  (vd_hi_i),
    .dec_in (vd_dec_i),
    .sig    (sig_w)
  );

  pcal_strobe_dec #(.DAC_W(DAC_W)) u_dec (
    .ph        (ph_q),
    .mode      (mode_q),
    .hi        (hi_q),
    .sig       (sig_w),
    .rst_pix   (rst_pix_o),
    .az_amp    (az_amp_o),
    .az_adc    (az_adc_o),
    .tx        (tx_o),
    .sh        (sh_o),
    .adc_start (adc_start_o),
    .ical_en   (ical_en_o),
    .ical_en_b (ical_en_b_o),
    .vdrain    (vdrain_o)
  );

  assign step_idx_o = step_q;
  assign busy_o     = (ph_q != PH_IDLE);
  assign done_o     = done_q;
  assign mode_o     = mode_q;
endmodule

// File: rtl/pcal_seq_chk.sv
module pcal_seq_chk #(
  parameter int NUM_STEPS = 4096,
  parameter int SW        = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_pix,
  input logic          az_amp,
  input logic          az_adc,
  input logic          tx,
  input logic          sh,
  input logic          adc_start,
  input logic          ical_en,
  input logic          busy,
  input logic          done,
  input logic [1:0]    mode,
  input logic [SW-1:0] step
);
  localparam logic [SW-1:0] LAST_STEP = SW'(NUM_STEPS - 1);

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({az_amp, az_adc, tx, sh, adc_start, ical_en}));

  p_amp_then_adc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(az_amp) |-> az_adc);

  p_adc_after_amp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(az_adc) |-> $past(az_amp));

  p_reset_during_az_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (az_amp || az_adc) |-> rst_pix);

  p_tx_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mode == 2'b01)) |-> !tx);

  p_tx_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mode == 2'b10)) |-> !tx);

  p_ical_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ical_en |-> (busy && (mode == 2'b10)));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode));

  p_step_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adc_start) |=> $stable(step));

  p_step_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && (step != LAST_STEP)) |=> (step == $past(step) + 1'b1));

  p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done);
endmodule

bind pcal_seq pcal_seq_chk #(.NUM_STEPS(NUM_STEPS), .SW(SW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_pix   (rst_pix_o),
  .az_amp    (az_amp_o),
  .az_adc    (az_adc_o),
  .tx        (tx_o),
  .sh        (sh_o),
  .adc_start (adc_start_o),
  .ical_en   (ical_en_o),
  .busy      (busy_o),
  .done      (done_o),
  .mode      (mode_o),
  .step      (step_idx_o)
);

// File: tb/pcal_seq_tb_top.sv
module pcal_seq_tb_top;
  localparam int N  = 6;
  localparam int SW = $clog2(N);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start_i;
  logic [1:0] mode_i;
  logic [7:0] unit_cyc_i, pulse_cyc_i;
  logic [13:0] vd_hi_i, vd_dec_i;
  logic rst_pix_o, az_amp_o, az_adc_o, tx_o, sh_o, adc_start_o, ical_en_o, ical_en_b_o;
  logic [13:0] vdrain_o;
  logic [SW-1:0] step_idx_o;
  logic busy_o, done_o;
  logic [1:0] mode_o;

  pcal_seq #(.NUM_STEPS(N), .UNIT_W(8), .PULSE_W(8), .DAC_W(14)) dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit noise = 0, finished = 0;

  task automatic cmp(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] pack_out();
    return {rst_pix_o, az_amp_o, az_adc_o, tx_o, sh_o, adc_start_o, ical_en_o,
            ical_en_b_o, busy_o, done_o, mode_o, step_idx_o, vdrain_o};
  endfunction

  function automatic logic [13:0] sig_of(int hi, int dec, int k);
    int v = hi - (k + 1) * dec;
    return (v < 0) ? 14'd0 : 14'(v);
  endfunction

  // s bits: rst_pix, az_amp, az_adc, tx, sh, adc_start, ical_en
  // ical_en_b is expected as the inverse of ical_en in every cycle (R7)
  task automatic cyc(string req, logic [6:0] s, logic [13:0] vd, int k, logic [1:0] md);
    logic [63:0] exp;
    exp = {s, ~s[0], 1'b1, 1'b0, md, SW'(k), vd};
    cmp(noise ? {req, " R9"} : req, pack_out(), exp);
    if (noise) begin
      start_i     = 1'($urandom);
      mode_i      = 2'($urandom);
      unit_cyc_i  = 8'($urandom);
      pulse_cyc_i = 8'($urandom);
      vd_hi_i     = 14'($urandom);
      vd_dec_i    = 14'($urandom);
    end
    @(negedge clk);
  endtask

  task automatic run_sweep(logic [1:0] md, int u, int p, int hi, int dec, bit nz);
    int ue, pe;
    logic [13:0] vh, vs;
    ue = (u == 0) ? 1 : u;
    pe = (p == 0) ? 1 : p;
    mode_i = md; unit_cyc_i = 8'(u); pulse_cyc_i = 8'(p);
    vd_hi_i = 14'(hi); vd_dec_i = 14'(dec);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    noise = nz;
    for (int k = 0; k < N; k++) begin
      vh = (md == 2'b01) ? 14'(hi) : 14'd0;
      vs = (md == 2'b01) ? sig_of(hi, dec, k) : 14'd0;
      if (md == 2'b00) begin
        for (int i = 0; i < pe; i++) cyc("R4 pd reset", 7'b1001000, 14'd0, k, md);
        for (int i = 0; i < (k + 1) * ue; i++) cyc("R4 exposure", 7'b0000000, 14'd0, k, md);
      end
      for (int i = 0; i < pe; i++) cyc("R3 amp az", 7'b1100000, vh, k, md);
      for (int i = 0; i < pe; i++) cyc("R3 adc az", 7'b1010000, vh, k, md);
      if (md == 2'b00)
        for (int i = 0; i < pe; i++) cyc("R4 transfer", 7'b0001000, 14'd0, k, md);
      else if (md == 2'b01)
        for (int i = 0; i < pe; i++) cyc("R5 drain signal", 7'b1000000, vs, k, md);
      else
        for (int i = 0; i < (k + 1) * ue; i++) cyc("R6 R7 ical pulse", 7'b0000001, 14'd0, k, md);
      for (int i = 0; i < pe; i++) cyc("R3 R5 sample hold", 7'b0000100, vs, k, md);
      cyc("R8 conversion", 7'b0000010, vh, k, md);
    end
    noise = 0;
    start_i = 1'b0;
    cmp("R8 sweep end", pack_out(),
        {7'b0, 1'b1, 1'b0, 1'b1, md, SW'(N - 1), 14'd0});
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; start_i = 0; mode_i = 0; unit_cyc_i = 0; pulse_cyc_i = 0;
    vd_hi_i = 0; vd_dec_i = 0;
    repeat (3) @(negedge clk);
    cmp("R1 in reset", pack_out(), {7'b0, 1'b1, 1'b0, 1'b0, 2'b00, SW'(0), 14'd0});
    rst_n = 1;
    @(negedge clk);
    cmp("R1 after reset", pack_out(), {7'b0, 1'b1, 1'b0, 1'b0, 2'b00, SW'(0), 14'd0});

    // R2: illegal mode code is refused
    mode_i = 2'b11; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cmp("R2 mode 11 refused", pack_out(), {7'b0, 1'b1, 1'b0, 1'b0, 2'b00, SW'(0), 14'd0});

    run_sweep(2'b00, 2, 1, 0, 0, 0);         // R4
    run_sweep(2'b01, 1, 2, 1000, 100, 0);    // R5
    run_sweep(2'b01, 1, 1, 250, 100, 0);     // R5 saturation at zero
    run_sweep(2'b10, 3, 1, 0, 0, 0);         // R6
    run_sweep(2'b00, 0, 0, 0, 0, 0);         // R9 zero lengths act as one
    run_sweep(2'b10, 0, 3, 5, 5, 0);         // R9 zero unit in current mode

    // R2 R8: refused start after a sweep keeps done and mode
    @(negedge clk);
    mode_i = 2'b11; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cmp("R2 R8 done held", pack_out(), {7'b0, 1'b1, 1'b0, 1'b1, 2'b10, SW'(N - 1), 14'd0});

    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      run_sweep(2'($urandom_range(0, 2)), int'($urandom_range(0, 4)),
                int'($urandom_range(0, 3)), int'($urandom_range(0, 16383)),
                int'($urandom_range(0, 3000)), 1'b1);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule